// File: doc/BRIEF.md
# Interrupt Status and Pin Controller

This block collects single-cycle event pulses into a sticky status register and drives an active-low interrupt line toward a host. The host clears the status by reading it. The serial access logic that performs that read lies outside the block. It tells the block that a read has finished with a one-cycle strobe, raised at the moment chip select rises. Each event bit has a mask bit. A masked bit is still recorded in the status, but it never pulls the line low.

Two line schemes are available. In the static scheme the line goes low when an unmasked bit becomes pending, and it stays low until the status is read. In the dynamic scheme the line alternates between a low phase and a high phase of fixed lengths for as long as unmasked bits remain pending. A status read that finds work outstanding starts a hold-off window. During the window the line is kept high, so an external pull-up can restore the level and an edge-sensitive host can see the next falling edge. The scheme bit can be written only while the run/trigger bit is clear.

Top module: `irq_status_pin_ctrl`

## Requirements
- R1: After reset, the interrupt line `irq_n_o` is 1, every bit of `status_o` is 0, and `scheme_o` is 0, which selects the static scheme.
- R2: An event pulse on bit i sets `status_o[i]` on the next clock edge. The bit then stays set on every following cycle until a read strobe arrives.
- R3: A read strobe clears `status_o` on the clock edge where it is sampled. An event bit sampled on that same edge stays set, so no event is lost.
- R4: A status bit whose mask bit is 1 never makes the line go low. Only bits that are both set and unmasked count as pending. If such a bit is later unmasked, it asserts the line.
- R5: In the static scheme, the line goes low one clock edge after a pending unmasked bit appears in `status_o`. It then stays low until a read strobe arrives.
- R6: A read strobe that is sampled while the line is low drives the line high on that same edge.
- R7: In the dynamic scheme (`scheme_o` = 1), while bits are pending the line is low for ACT_CYC cycles and then high for INACT_CYC cycles. This pattern repeats.
- R8: In the dynamic scheme, a read during the high phase clears the status. If no new event follows, the line is never driven low again.
- R9: A read that finds pending unmasked bits, or finds the line cycling, keeps the line high for IDLE_CYC cycles. An event that arrives inside this window shows in `status_o` on the next edge. The line goes low only on the edge that ends the window.
- R10: A second read inside the hold-off window clears the status again. The window does not restart, and the line stays high after the window ends unless a new event has arrived.
- R11: A write strobe on `scheme_wr_i` loads `scheme_wdata_i` into `scheme_o` only while `trigger_i` is 0. While `trigger_i` is 1, the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_EVT | Single-cycle event pulses |
| mask_i | input | N_EVT | Per-bit mask; 1 stops that bit from asserting the line |
| rd_strobe_i | input | 1 | One-cycle strobe at the chip-select rising edge that ends a status read |
| scheme_wr_i | input | 1 | Write strobe for the scheme bit |
| scheme_wdata_i | input | 1 | Scheme value to write: 0 static, 1 dynamic |
| trigger_i | input | 1 | Run/trigger bit; while it is 1, scheme writes are blocked |
| scheme_o | output | 1 | Scheme currently in force |
| status_o | output | N_EVT | Sticky status content |
| irq_n_o | output | 1 | Registered active-low interrupt line |

## Verification
On every cycle, the assertions check four things. Status bits fall only on a read. Events are captured on the next edge. A blocked scheme write leaves the scheme unchanged. The line is high during the hold-off window, right after a read of a low line, and while nothing is pending from an idle state. Only the directed scenarios can show the exact cycle counts: the low and high phase lengths of the dynamic scheme, the length of the hold-off window, and whether the line reasserts once the window ends. The scenarios also cover a masked bit being unmasked later and an event that coincides with the clearing read.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    PIN_IDLE   = 2'd0,
    PIN_ASSERT = 2'd1,
    PIN_RELAX  = 2'd2,
    PIN_HOLD   = 2'd3
  } pin_state_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic             rd_i,
  output logic [N_EVT-1:0] status_o,
  output logic             pending_o
);
  logic [N_EVT-1:0] status_q, status_d;

  // Clear on read; an event on the clearing edge wins (R3)
  always_comb begin
    status_d = rd_i ? '0 : status_q;
    status_d = status_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o  = status_q;
  assign pending_o = |(status_q & ~mask_i);

  // R2: bits never drop without a read
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R2/R3: every event bit is present after the edge, read or not
  p_event_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  // R3: read with no event empties the status
  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && evt_i == '0) |=> (status_q == '0));
endmodule

// File: rtl/irq_scheme_reg.sv
module irq_scheme_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic trigger_i,
  output logic scheme_o
);
  logic scheme_q, scheme_d, scheme_en;

  assign scheme_en = wr_i && !trigger_i;

  always_comb begin
    scheme_d = scheme_q;
    if (scheme_en) scheme_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scheme_q <= 1'b0;
    else        scheme_q <= scheme_d;
  end

  assign scheme_o = scheme_q;

  // R11: a running trigger freezes the scheme bit
  p_locked_scheme_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_i |=> $stable(scheme_q));
endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
  import irq_ctrl_pkg::*;
#(
  parameter int ACT_CYC   = 4,
  parameter int INACT_CYC = 6,
  parameter int IDLE_CYC  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic rd_i,
  input  logic scheme_i,
  output logic irq_n_o
);
  localparam int MAX_CYC = (ACT_CYC > INACT_CYC) ?
                           ((ACT_CYC > IDLE_CYC) ? ACT_CYC : IDLE_CYC) :
                           ((INACT_CYC > IDLE_CYC) ? INACT_CYC : IDLE_CYC);
  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] ACT_LD   = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] INACT_LD = CW'(INACT_CYC - 1);
  localparam logic [CW-1:0] IDLE_LD  = CW'(IDLE_CYC - 1);

  pin_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_n_q, irq_n_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    if (rd_i && (pending_i || state_q != PIN_IDLE)) begin
      state_d = PIN_HOLD;
      if (state_q != PIN_HOLD) cnt_d = IDLE_LD;
    end else begin
      unique case (state_q)
        PIN_IDLE: if (pending_i) begin
          state_d = PIN_ASSERT;
          cnt_d   = ACT_LD;
        end
        PIN_ASSERT: if (scheme_i && cnt_zero) begin
          state_d = PIN_RELAX;
          cnt_d   = INACT_LD;
        end
        PIN_RELAX: if (cnt_zero) begin
          state_d = pending_i ? PIN_ASSERT : PIN_IDLE;
          cnt_d   = ACT_LD;
        end
        PIN_HOLD: if (cnt_zero) begin
          state_d = pending_i ? PIN_ASSERT : PIN_IDLE;
          cnt_d   = ACT_LD;
        end
        default: state_d = PIN_IDLE;
      endcase
    end
    irq_n_d = (state_d != PIN_ASSERT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PIN_IDLE;
      cnt_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n_o = irq_n_q;

  // R9: line is high throughout the hold-off window
  p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PIN_HOLD) |-> irq_n_q);
  // R6: a read of a low line releases it on that edge
  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !irq_n_q) |=> irq_n_q);
  // R4: nothing pending from idle keeps the line high
  p_quiet_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PIN_IDLE && !pending_i) |=> irq_n_q);
  // R5: static scheme holds the line low until a read
  p_static_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scheme_i && !irq_n_q && !rd_i) |=> !irq_n_q);
endmodule

// File: rtl/irq_status_pin_ctrl.sv
module irq_status_pin_ctrl #(
  parameter int N_EVT     = 8,
  parameter int ACT_CYC   = 4,
  parameter int INACT_CYC = 6,
  parameter int IDLE_CYC  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic             rd_strobe_i,
  input  logic             scheme_wr_i,
  input  logic             scheme_wdata_i,
  input  logic             trigger_i,
  output logic             scheme_o,
  output logic [N_EVT-1:0] status_o,
  output logic             irq_n_o
);
  logic pending;
  logic scheme;

  irq_status_reg #(.N_EVT(N_EVT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .mask_i    (mask_i),
    .rd_i      (rd_strobe_i),
    .status_o  (status_o),
    .pending_o (pending)
  );

  irq_scheme_reg u_scheme (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (scheme_wr_i),
    .wdata_i   (scheme_wdata_i),
    .trigger_i (trigger_i),
    .scheme_o  (scheme)
  );

  irq_pin_fsm #(
    .ACT_CYC   (ACT_CYC),
    .INACT_CYC (INACT_CYC),
    .IDLE_CYC  (IDLE_CYC)
  ) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .rd_i      (rd_strobe_i),
    .scheme_i  (scheme),
    .irq_n_o   (irq_n_o)
  );

  assign scheme_o = scheme;
endmodule

// File: tb/irq_status_pin_ctrl_tb.sv
`timescale 1ns/1ps
module irq_status_pin_ctrl_tb_top;
  localparam int N   = 8;
  localparam int ACT = 4;
  localparam int INA = 6;
  localparam int IDL = 5;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] evt, mask;
  logic         rd, swr, swd, trig;
  logic         scheme;
  logic [N-1:0] status;
  logic         irq_n;

  int n_run  = 0;
  int n_fail = 0;

  irq_status_pin_ctrl #(.N_EVT(N), .ACT_CYC(ACT), .INACT_CYC(INA), .IDLE_CYC(IDL)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .mask_i(mask), .rd_strobe_i(rd),
    .scheme_wr_i(swr), .scheme_wdata_i(swd), .trigger_i(trig),
    .scheme_o(scheme), .status_o(status), .irq_n_o(irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    evt = '0; mask = '0; rd = 0; swr = 0; swd = 0; trig = 0;
    rst_n = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic pulse_evt(input logic [N-1:0] v);
    evt = v; step(1); evt = '0;
  endtask

  task automatic pulse_rd();
    rd = 1; step(1); rd = 0;
  endtask

  task automatic set_dynamic();
    swr = 1; swd = 1; step(1); swr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq_n", irq_n, 1);
    chk("R1 status", status, 0);
    chk("R1 scheme", scheme, 0);
  endtask

  task automatic t_static();
    do_reset();
    pulse_evt(8'h05);
    chk("R2 status set", status, 8'h05);
    chk("R5 not yet low", irq_n, 1);
    step(1);
    chk("R5 low", irq_n, 0);
    step(10);
    chk("R5 still low", irq_n, 0);
    chk("R2 sticky", status, 8'h05);
    pulse_rd();
    chk("R6 released", irq_n, 1);
    chk("R3 cleared", status, 0);
    step(IDL + 3);
    chk("R9 no reassert when nothing pending", irq_n, 1);
  endtask

  task automatic t_coincide();
    do_reset();
    pulse_evt(8'h01);
    step(2);
    evt = 8'h80; rd = 1; step(1); evt = '0; rd = 0;
    chk("R3 coincident event kept", status, 8'h80);
    chk("R6 released", irq_n, 1);
    step(IDL - 1);
    chk("R9 high to end of window", irq_n, 1);
    step(1);
    chk("R9 low after window", irq_n, 0);
  endtask

  task automatic t_mask();
    do_reset();
    mask = 8'h02;
    pulse_evt(8'h02);
    chk("R4 masked bit recorded", status, 8'h02);
    for (int i = 0; i < 8; i++) begin
      step(1);
      chk("R4 masked stays high", irq_n, 1);
    end
    mask = '0;
    step(2);
    chk("R4 unmasked asserts", irq_n, 0);
  endtask

  task automatic t_holdoff();
    do_reset();
    pulse_evt(8'h01);
    step(3);
    pulse_rd();
    chk("R9 high after read", irq_n, 1);
    pulse_evt(8'h10);
    chk("R9 event shows at once", status, 8'h10);
    step(IDL - 2);
    chk("R9 still high in window", irq_n, 1);
    step(1);
    chk("R9 low after window", irq_n, 0);
  endtask

  task automatic t_second_read();
    do_reset();
    pulse_evt(8'h01);
    step(3);
    pulse_rd();
    pulse_evt(8'h20);
    chk("R10 event in window", status, 8'h20);
    pulse_rd();
    chk("R10 cleared again", status, 0);
    step(IDL + 4);
    chk("R10 no reassert", irq_n, 1);
  endtask

  task automatic t_dynamic();
    do_reset();
    set_dynamic();
    chk("R11 write with trigger 0", scheme, 1);
    pulse_evt(8'h04);
    step(1);
    for (int i = 0; i < ACT; i++) begin
      chk("R7 low phase", irq_n, 0); step(1);
    end
    for (int i = 0; i < INA; i++) begin
      chk("R7 high phase", irq_n, 1); step(1);
    end
    chk("R7 low again", irq_n, 0);
    step(ACT + 2);
    chk("R8 in high phase", irq_n, 1);
    pulse_rd();
    chk("R8 status cleared", status, 0);
    for (int i = 0; i < IDL + INA + ACT; i++) begin
      chk("R8 never low again", irq_n, 1); step(1);
    end
  endtask

  task automatic t_trigger();
    do_reset();
    trig = 1;
    swr = 1; swd = 1; step(1); swr = 0;
    chk("R11 write blocked by trigger", scheme, 0);
    pulse_evt(8'h01);
    step(ACT + 3);
    chk("R11 static still in force", irq_n, 0);
    trig = 0;
    swr = 1; swd = 1; step(1); swr = 0;
    chk("R11 write accepted", scheme, 1);
  endtask

  initial begin
    t_reset();
    t_static();
    t_coincide();
    t_mask();
    t_holdoff();
    t_second_read();
    t_dynamic();
    t_trigger();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule